// File: doc/BRIEF.md
# RAS-only to CAS-before-RAS refresh converter

This block sits between a DRAM controller and a bank of DRAMs that refresh only through CAS-before-RAS (CBR) cycles. The controller issues refresh as RAS-only cycles, in which the row strobe is asserted and no column strobe is. The block runs entirely on the dot clock. Ordinary read and write cycles pass through it unchanged, apart from a fixed latency. When a cycle with no column strobe arrives, the block replaces it with a CBR sequence on the memory side. First every column strobe output goes low. One dot clock later the row strobe output goes low. The row strobe output is released first and the column strobes after it.

All strobes are active low. A short delay line of `PIPE_DEPTH` stages gives the block a lookahead window over the controller's strobes. The block decides a cycle's type as that cycle's row-strobe fall leaves the delay line, so it can classify the cycle before it drives anything to the memories. All `NCAS` column strobe outputs move together during a substituted refresh.

Top module: `refresh_cbr_converter`

## Requirements
- R1: Relay. A cycle is relayed when some column strobe lane is low while `ctl_ras_n` is low, within the first `PIPE_DEPTH` samples of the row-strobe low period. This includes the sample in which `ctl_ras_n` falls. For such a cycle, `mem_ras_n` and `mem_cas_n` equal the controller's strobes delayed by exactly `PIPE_DEPTH`+1 dot clocks. This also holds whenever `ctl_ras_n` is high.
- R2: Refresh detection. A cycle is converted when `ctl_ras_n` stays low for at least 2 samples and every `ctl_cas_n` lane stays high over the first `PIPE_DEPTH` samples of the low period. Column strobes that fall later in that cycle have no effect on the outputs.
- R3: Column strobes first. In a converted cycle all `mem_cas_n` lanes go low together, `PIPE_DEPTH`+1 clocks after the controller's row-strobe fall. At that point `mem_ras_n` is still high, and it falls one clock later.
- R4: During a substituted refresh, `mem_cas_n` is all zeros in every cycle in which `mem_ras_n` is low.
- R5: Release order. With the controller's row strobe low for N samples, `mem_ras_n` is low for N-1 cycles. It then goes high while `mem_cas_n` stays all zeros for one more cycle. After that the outputs follow the relay path again.
- R6: While `rst` is high, and on the first clock after it is asserted even in the middle of a refresh, `mem_ras_n` and every `mem_cas_n` lane are high. The block then resumes in relay mode.
- R7: Back-to-back refresh cycles separated by a single high sample of `ctl_ras_n` are each converted. `mem_ras_n` falls once per controller refresh cycle, and `mem_cas_n` may stay low across the gap.
- R8: A normal cycle that begins one sample after a converted refresh ends is relayed with the R1 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dot_clk | input | 1 | Dot clock, the only clock of the block |
| rst | input | 1 | Synchronous reset, active high |
| ctl_ras_n | input | 1 | Row strobe from the controller, active low |
| ctl_cas_n | input | NCAS | Column strobes from the controller, active low |
| mem_ras_n | output | 1 | Row strobe to the memories, active low |
| mem_cas_n | output | NCAS | Column strobes to the memories, active low |

## Verification
Two functions can land in the same dot clock. One is the release of a substituted refresh, where the row strobe goes up and the column strobes are held. The other is the detection of the next refresh, or of a normal cycle, whose row-strobe fall reaches the end of the delay line one sample later. The bench provokes this with two refresh cycles separated by one high sample, and with a refresh followed directly by a read. It then checks, cycle by cycle, that the column strobes stay low through the join and that exactly two row-strobe falls appear, or that the read comes out with the relay latency. A column strobe placed exactly at the last lookahead sample, and one placed a sample beyond it, marks the boundary between relay and conversion.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RELAY = 2'd1,
    SEQ_CBR   = 2'd2
  } seq_state_e;

  // clocks from a controller sample to the matching memory-side strobe
  function automatic int unsigned relay_latency(input int unsigned depth);
    return depth + 1;
  endfunction

endpackage

// File: rtl/rcr_strobe_delay.sv
module rcr_strobe_delay #(
  parameter int unsigned NCAS  = 1,
  parameter int unsigned DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             in_ras_n,
  input  logic [NCAS-1:0]                  in_cas_n,
  output logic [DEPTH-1:0]                 ras_q,
  output logic [DEPTH-1:0][NCAS-1:0]       cas_q
);

  // stage 0 holds the newest sample, stage DEPTH-1 is the tap
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          ras_q[g] <= 1'b1;
          cas_q[g] <= '1;
        end else begin
          ras_q[g] <= in_ras_n;
          cas_q[g] <= in_cas_n;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          ras_q[g] <= 1'b1;
          cas_q[g] <= '1;
        end else begin
          ras_q[g] <= ras_q[g-1];
          cas_q[g] <= cas_q[g-1];
        end
      end
    end
  end

endmodule

// File: rtl/rcr_cas_scan.sv
module rcr_cas_scan #(
  parameter int unsigned NCAS  = 1,
  parameter int unsigned DEPTH = 4
) (
  input  logic [DEPTH-1:0]           ras_q,
  input  logic [DEPTH-1:0][NCAS-1:0] cas_q,
  output logic                       cas_in_window
);

  // Walk from the tap toward newer samples while the row strobe stays low;
  // report whether any column lane was low inside that run.
  function automatic logic scan_window(input logic [DEPTH-1:0]           r,
                                       input logic [DEPTH-1:0][NCAS-1:0] c);
    logic run;
    logic hit;
    run = 1'b1;
    hit = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (run) begin
        if (r[i]) begin
          run = 1'b0;
        end else if (!(&c[i])) begin
          hit = 1'b1;
        end
      end
    end
    return hit;
  endfunction

  assign cas_in_window = scan_window(ras_q, cas_q);

endmodule

// File: rtl/rcr_cbr_seq.sv
module rcr_cbr_seq
  import rcr_pkg::*;
#(
  parameter int unsigned NCAS = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tap_ras_n,
  input  logic [NCAS-1:0] tap_cas_n,
  input  logic            cas_in_window,
  output logic            ras_n,
  output logic [NCAS-1:0] cas_n,
  output logic            cbr_active,
  output logic            cbr_start,
  output logic            relay_q
);

  seq_state_e      st, st_nxt;
  logic            ras_d;
  logic [NCAS-1:0] cas_d;
  logic            relay_d;

  always_comb begin
    st_nxt    = st;
    ras_d     = tap_ras_n;
    cas_d     = tap_cas_n;
    relay_d   = 1'b1;
    cbr_start = 1'b0;
    unique case (st)
      SEQ_IDLE: begin
        if (!tap_ras_n && !cas_in_window) begin
          // refresh found: column strobes down, row strobe held up
          ras_d     = 1'b1;
          cas_d     = '0;
          relay_d   = 1'b0;
          cbr_start = 1'b1;
          st_nxt    = SEQ_CBR;
        end else if (!tap_ras_n) begin
          st_nxt = SEQ_RELAY;
        end
      end
      SEQ_RELAY: begin
        if (tap_ras_n) st_nxt = SEQ_IDLE;
      end
      SEQ_CBR: begin
        // row strobe tracks the tap, column strobes pinned low
        relay_d = 1'b0;
        cas_d   = '0;
        ras_d   = tap_ras_n;
        if (tap_ras_n) st_nxt = SEQ_IDLE;
      end
      default: st_nxt = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SEQ_IDLE;
      ras_n   <= 1'b1;
      cas_n   <= '1;
      relay_q <= 1'b0;
    end else begin
      st      <= st_nxt;
      ras_n   <= ras_d;
      cas_n   <= cas_d;
      relay_q <= relay_d;
    end
  end

  assign cbr_active = (st == SEQ_CBR);

endmodule

// File: rtl/refresh_cbr_converter.sv
module refresh_cbr_converter
  import rcr_pkg::*;
#(
  parameter int unsigned NCAS       = 1,
  parameter int unsigned PIPE_DEPTH = 4
) (
  input  logic            dot_clk,
  input  logic            rst,
  input  logic            ctl_ras_n,
  input  logic [NCAS-1:0] ctl_cas_n,
  output logic            mem_ras_n,
  output logic [NCAS-1:0] mem_cas_n
);

  localparam int unsigned TAP = PIPE_DEPTH - 1;
  localparam int unsigned LAT = relay_latency(PIPE_DEPTH);

  logic [PIPE_DEPTH-1:0]           dl_ras;
  logic [PIPE_DEPTH-1:0][NCAS-1:0] dl_cas;
  logic                            cas_in_window;
  logic                            cbr_active;
  logic                            cbr_start;
  logic                            relay_q;

  rcr_strobe_delay #(.NCAS(NCAS), .DEPTH(PIPE_DEPTH)) u_delay (
    .clk      (dot_clk),
    .rst      (rst),
    .in_ras_n (ctl_ras_n),
    .in_cas_n (ctl_cas_n),
    .ras_q    (dl_ras),
    .cas_q    (dl_cas)
  );

  rcr_cas_scan #(.NCAS(NCAS), .DEPTH(PIPE_DEPTH)) u_scan (
    .ras_q         (dl_ras),
    .cas_q         (dl_cas),
    .cas_in_window (cas_in_window)
  );

  rcr_cbr_seq #(.NCAS(NCAS)) u_seq (
    .clk           (dot_clk),
    .rst           (rst),
    .tap_ras_n     (dl_ras[TAP]),
    .tap_cas_n     (dl_cas[TAP]),
    .cas_in_window (cas_in_window),
    .ras_n         (mem_ras_n),
    .cas_n         (mem_cas_n),
    .cbr_active    (cbr_active),
    .cbr_start     (cbr_start),
    .relay_q       (relay_q)
  );

  if (PIPE_DEPTH < 2 || LAT != PIPE_DEPTH + 1) begin : g_bad_depth
    initial $error("PIPE_DEPTH must be at least 2");
  end

endmodule

// File: rtl/rcr_converter_chk.sv
module rcr_converter_chk #(
  parameter int unsigned NCAS  = 1,
  parameter int unsigned DEPTH = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            ctl_ras_n,
  input logic [NCAS-1:0] ctl_cas_n,
  input logic            mem_ras_n,
  input logic [NCAS-1:0] mem_cas_n,
  input logic            cbr_active,
  input logic            relay_q
);

  // independent history of the controller strobes, DEPTH+1 deep
  logic [DEPTH:0]           h_ras;
  logic [DEPTH:0][NCAS-1:0] h_cas;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_ras <= '1;
      h_cas <= '1;
    end else begin
      h_ras <= {h_ras[DEPTH-1:0], ctl_ras_n};
      h_cas <= {h_cas[DEPTH-1:0], ctl_cas_n};
    end
  end

  a_r1_relay_latency: assert property (@(posedge clk) disable iff (rst)
    relay_q |-> (mem_ras_n == h_ras[DEPTH] && mem_cas_n == h_cas[DEPTH]));

  a_r2_detect_on_ras_low: assert property (@(posedge clk) disable iff (rst)
    $rose(cbr_active) |-> (!h_ras[DEPTH] && mem_ras_n && mem_cas_n == '0));

  a_r3_cas_before_ras: assert property (@(posedge clk) disable iff (rst)
    ($fell(mem_ras_n) && cbr_active) |-> ($past(mem_cas_n) == '0));

  a_r4_cas_held: assert property (@(posedge clk) disable iff (rst)
    (cbr_active && !mem_ras_n) |-> (mem_cas_n == '0));

  a_r5_ras_released_first: assert property (@(posedge clk) disable iff (rst)
    $fell(cbr_active) |-> (mem_ras_n && mem_cas_n == '0));

  a_r6_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (mem_ras_n && (&mem_cas_n)));

endmodule

bind refresh_cbr_converter rcr_converter_chk #(.NCAS(NCAS), .DEPTH(PIPE_DEPTH)) u_chk (
  .clk        (dot_clk),
  .rst        (rst),
  .ctl_ras_n  (ctl_ras_n),
  .ctl_cas_n  (ctl_cas_n),
  .mem_ras_n  (mem_ras_n),
  .mem_cas_n  (mem_cas_n),
  .cbr_active (cbr_active),
  .relay_q    (relay_q)
);

// File: tb/test_refresh_cbr_converter.sv
module test_refresh_cbr_converter;

  localparam int NC  = 2;
  localparam int PD  = 4;
  localparam int LAT = PD + 1;
  localparam int NS  = 40;

  logic          dot_clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_ras_n = 1'b1;
  logic [NC-1:0] ctl_cas_n = '1;
  logic          mem_ras_n;
  logic [NC-1:0] mem_cas_n;

  int n_chk  = 0;
  int n_fail = 0;

  logic          s_ras [NS];
  logic [NC-1:0] s_cas [NS];
  logic          g_ras [NS];
  logic [NC-1:0] g_cas [NS];

  always #5 dot_clk = ~dot_clk;

  refresh_cbr_converter #(.NCAS(NC), .PIPE_DEPTH(PD)) i_refresh_cbr_converter (
    .dot_clk   (dot_clk),
    .rst       (rst),
    .ctl_ras_n (ctl_ras_n),
    .ctl_cas_n (ctl_cas_n),
    .mem_ras_n (mem_ras_n),
    .mem_cas_n (mem_cas_n)
  );

  task automatic check(input bit ok, input string tag, input logic ar,
                       input logic [NC-1:0] ac, input logic er, input logic [NC-1:0] ec);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: ras=%b cas=%b expected ras=%b cas=%b", tag, ar, ac, er, ec);
    end
  endtask

  task automatic stim_idle();
    for (int i = 0; i < NS; i++) begin
      s_ras[i] = 1'b1;
      s_cas[i] = '1;
    end
  endtask

  task automatic ras_low(input int lo, input int hi);
    for (int i = lo; i <= hi; i++) s_ras[i] = 1'b0;
  endtask

  task automatic cas_low(input int lane, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) s_cas[i][lane] = 1'b0;
  endtask

  // drive one sample per negedge, logging the output first
  task automatic run();
    for (int i = 0; i < NS; i++) begin
      @(negedge dot_clk);
      g_ras[i]  = mem_ras_n;
      g_cas[i]  = mem_cas_n;
      ctl_ras_n = s_ras[i];
      ctl_cas_n = s_cas[i];
    end
  endtask

  task automatic chk_at(input int k, input logic er, input logic [NC-1:0] ec, input string tag);
    check(g_ras[k] === er && g_cas[k] === ec, $sformatf("%s @%0d", tag, k),
          g_ras[k], g_cas[k], er, ec);
  endtask

  task automatic chk_relay(input int lo, input int hi, input string tag);
    for (int k = lo; k <= hi; k++) chk_at(k + LAT, s_ras[k], s_cas[k], tag);
  endtask

  // every row-strobe fall must follow, and coincide with, all column strobes low
  task automatic chk_order(input string tag);
    for (int k = 1; k < NS; k++) begin
      if (g_ras[k-1] && !g_ras[k])
        check(g_cas[k-1] == '0 && g_cas[k] == '0, tag, g_ras[k], g_cas[k-1], 1'b0, '0);
      if (!g_ras[k])
        check(g_cas[k] == '0, {tag, " held"}, g_ras[k], g_cas[k], 1'b0, '0);
    end
  endtask

  function automatic int ras_falls();
    int n = 0;
    for (int k = 1; k < NS; k++) if (g_ras[k-1] && !g_ras[k]) n++;
    return n;
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge dot_clk);
    check(mem_ras_n === 1'b1 && mem_cas_n === '1, "R6 in reset", mem_ras_n, mem_cas_n, 1'b1, '1);
    rst = 1'b0;
    repeat (LAT + 2) @(negedge dot_clk);
    check(mem_ras_n === 1'b1 && mem_cas_n === '1, "R6 idle after reset", mem_ras_n, mem_cas_n, 1'b1, '1);
  endtask

  task automatic t_read_page();
    stim_idle();
    ras_low(2, 9);
    cas_low(1, 4, 5);
    cas_low(1, 7, 8);
    cas_low(0, 5, 5);
    run();
    chk_relay(0, 30, "R1 page relay");
  endtask

  task automatic t_window_edges();
    stim_idle();
    ras_low(2, 5);
    cas_low(0, 2, 4);
    run();
    chk_relay(0, 30, "R1 cas with ras");
    stim_idle();
    ras_low(2, 8);
    cas_low(0, 5, 7);
    run();
    chk_relay(0, 30, "R1 cas at last lookahead");
  endtask

  task automatic t_single_refresh();
    stim_idle();
    ras_low(2, 7);
    run();
    chk_at(2 + LAT - 1, 1'b1, '1, "R3 idle before");
    chk_at(2 + LAT, 1'b1, '0, "R3 cas first");
    for (int k = 3; k <= 7; k++) chk_at(k + LAT, 1'b0, '0, "R8 ras low span");
    chk_at(8 + LAT, 1'b1, '0, "R5 ras released first");
    chk_at(9 + LAT, 1'b1, '1, "R5 cas released");
    chk_order("R4 order single");
  endtask

  task automatic t_late_cas();
    stim_idle();
    ras_low(2, 9);
    cas_low(0, 6, 8);
    run();
    chk_at(2 + LAT, 1'b1, '0, "R2 late cas converted");
    for (int k = 3; k <= 9; k++) chk_at(k + LAT, 1'b0, '0, "R2 late cas ignored");
    chk_at(10 + LAT, 1'b1, '0, "R5 late cas release");
    chk_at(11 + LAT, 1'b1, '1, "R5 late cas idle");
  endtask

  task automatic t_back_to_back();
    stim_idle();
    ras_low(2, 5);
    ras_low(7, 10);
    run();
    chk_at(7, 1'b1, '0, "R7 first cas");
    for (int k = 8; k <= 10; k++) chk_at(k, 1'b0, '0, "R7 first ras");
    chk_at(11, 1'b1, '0, "R7 gap release");
    chk_at(12, 1'b1, '0, "R7 second cas");
    for (int k = 13; k <= 15; k++) chk_at(k, 1'b0, '0, "R7 second ras");
    chk_at(16, 1'b1, '0, "R7 second release");
    chk_at(17, 1'b1, '1, "R7 idle");
    n_chk++;
    if (ras_falls() != 2) begin
      n_fail++;
      $display("FAIL R7 ras fall count: actual %0d expected 2", ras_falls());
    end
    chk_order("R3 order back-to-back");
  endtask

  task automatic t_refresh_then_read();
    stim_idle();
    ras_low(2, 5);
    ras_low(7, 11);
    cas_low(1, 8, 10);
    run();
    chk_at(7, 1'b1, '0, "R8 refresh cas");
    chk_at(11, 1'b1, '0, "R8 refresh release");
    chk_relay(7, 25, "R8 read after refresh");
  endtask

  task automatic t_reset_in_refresh();
    @(negedge dot_clk);
    ctl_ras_n = 1'b0;
    repeat (LAT + 2) @(negedge dot_clk);
    check(mem_ras_n === 1'b0 && mem_cas_n === '0, "R4 mid refresh", mem_ras_n, mem_cas_n, 1'b0, '0);
    rst = 1'b1;
    @(negedge dot_clk);
    check(mem_ras_n === 1'b1 && mem_cas_n === '1, "R6 reset mid refresh", mem_ras_n, mem_cas_n, 1'b1, '1);
    ctl_ras_n = 1'b1;
    @(negedge dot_clk);
    rst = 1'b0;
    repeat (LAT + 2) @(negedge dot_clk);
    check(mem_ras_n === 1'b1 && mem_cas_n === '1, "R6 resume", mem_ras_n, mem_cas_n, 1'b1, '1);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_read_page();
    t_window_edges();
    t_single_refresh();
    t_late_cas();
    t_back_to_back();
    t_refresh_then_read();
    t_reset_in_refresh();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule